// File: doc/BRIEF.md
# Remote Upgrade Control Register Chain

This block is a serially accessed control register for a remote configuration-upgrade controller. User logic supplies a clock, a serial data bit and two mode controls. It uses these to move words in and out of a 41-bit chain. The chain has two parts. The low 39 bits carry data. The top two bits select which status source a capture loads.

The data field can take one of three jobs. It can be written into a 39-bit parameter register that drives the downstream reconfiguration logic. It can be refilled with a status word and then shifted back out. The status word is one of four sources:

- the live state word;
- the state word of the first previous application, zero-padded;
- the state word of the second previous application, zero-padded;
- the parameter register itself, so that a written value can be read back.

Every clock edge performs exactly one operation. Shift takes priority over the other two. When shifting is off, the capture control picks capture or update.

Top module: `upg_ctl_chain`

## Requirements
- R1: A synchronous active-high `rst` clears both the 41-bit chain and the 39-bit parameter register `cfg_word` to zero.
- R2: With `mode_shift`=1, each clock moves `ser_in` into chain bit 40 and moves every bit one place toward bit 0. `ser_out` always shows chain bit 0, so a word shifted in LSB first occupies the chain in the same bit order after 41 clocks.
- R3: With `mode_shift`=1, the value of `mode_capture` has no effect on the chain or on `cfg_word`.
- R4: With both controls at 0 (update), `cfg_word` loads chain bits 38:0 on the clock edge, and the chain keeps its contents.
- R5: With `mode_shift`=0 and `mode_capture`=1 (capture) and chain bits 40:39 equal to 2'b00, chain bits 38:0 load `live_state`.
- R6: Capture with selector 2'b01 loads chain bits 38:0 with {8'b0, `prev_state_a`}.
- R7: Capture with selector 2'b10 loads chain bits 38:0 with {8'b0, `prev_state_b`}.
- R8: Capture with selector 2'b11 loads chain bits 38:0 with the current `cfg_word`.
- R9: In capture, chain bits 40:39 keep their value, so repeated captures keep using the same source.
- R10: `cfg_word` holds its value during shift and capture, and changes only in update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data entering chain bit 40 |
| mode_shift | input | 1 | 1 selects shift; it overrides `mode_capture` |
| mode_capture | input | 1 | When not shifting: 1 selects capture, 0 selects update |
| live_state | input | 39 | Current-state status word |
| prev_state_a | input | 31 | State word of the first previous application |
| prev_state_b | input | 31 | State word of the second previous application |
| ser_out | output | 1 | Chain bit 0 |
| cfg_word | output | 39 | Parameter register contents |

## Verification
The bench walks all four selector codes against several status patterns, and it reads every result back through the serial output.

- A swapped or mis-decoded selector shows up as the wrong source in the field.
- A missing zero pad lets high bits leak into bits 38:31.
- A capture that overwrote bits 40:39 would corrupt the second of two back-to-back captures.

During every shift the bench toggles the capture control and tracks the parameter register across all operations. This catches a design that lets that control leak into shifting, or that writes the register outside update. After each update the bench shifts the chain out in full, which exposes an update that disturbs the chain.

// File: rtl/upg_chain_pkg.sv
package upg_chain_pkg;

   typedef enum logic [1:0] {
      OP_UPDATE  = 2'd0,
      OP_CAPTURE = 2'd1,
      OP_SHIFT   = 2'd2
   } chain_op_e;

   localparam int unsigned SRC_SEL_W = 2;

   localparam logic [SRC_SEL_W-1:0] SRC_LIVE     = 2'b00;
   localparam logic [SRC_SEL_W-1:0] SRC_PREV_A   = 2'b01;
   localparam logic [SRC_SEL_W-1:0] SRC_PREV_B   = 2'b10;
   localparam logic [SRC_SEL_W-1:0] SRC_READBACK = 2'b11;

   // Shift has priority; capture and update split on the second control.
   function automatic chain_op_e decode_op(input logic shift_i, input logic capt_i);
      if (shift_i)     return OP_SHIFT;
      else if (capt_i) return OP_CAPTURE;
      else             return OP_UPDATE;
   endfunction

endpackage

// File: rtl/upg_capture_mux.sv
module upg_capture_mux
   import upg_chain_pkg::*;
#(
   parameter int unsigned FIELD_W = 39,
   parameter int unsigned PREV_W  = 31
) (
   input  logic [SRC_SEL_W-1:0] sel,
   input  logic [FIELD_W-1:0]   live,
   input  logic [PREV_W-1:0]    prev_a,
   input  logic [PREV_W-1:0]    prev_b,
   input  logic [FIELD_W-1:0]   readback,
   output logic [FIELD_W-1:0]   cap_word
);

   localparam int unsigned PAD_W = FIELD_W - PREV_W;

   logic [FIELD_W-1:0] prev_a_ext;
   logic [FIELD_W-1:0] prev_b_ext;

   generate
      if (PREV_W > FIELD_W) begin : g_bad_width
         $error("upg_capture_mux: PREV_W must not exceed FIELD_W");
      end

      if (PREV_W < FIELD_W) begin : g_pad
         assign prev_a_ext = {{PAD_W{1'b0}}, prev_a};
         assign prev_b_ext = {{PAD_W{1'b0}}, prev_b};
      end else begin : g_nopad
         assign prev_a_ext = prev_a;
         assign prev_b_ext = prev_b;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SRC_LIVE:   cap_word = live;
         SRC_PREV_A: cap_word = prev_a_ext;
         SRC_PREV_B: cap_word = prev_b_ext;
         default:    cap_word = readback;
      endcase
   end

endmodule

// File: rtl/upg_shift_chain.sv
module upg_shift_chain
   import upg_chain_pkg::*;
#(
   parameter int unsigned FIELD_W = 39
) (
   input  logic                  clk,
   input  logic                  rst,
   input  chain_op_e             op,
   input  logic                  ser_in,
   input  logic [FIELD_W-1:0]    cap_word,
   output logic [FIELD_W-1:0]    field_q,
   output logic [SRC_SEL_W-1:0]  sel_q,
   output logic                  ser_out
);

   localparam int unsigned CHAIN_W = FIELD_W + SRC_SEL_W;

   generate
      if (FIELD_W < 2) begin : g_bad_field
         $error("upg_shift_chain: FIELD_W must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else begin
         case (op)
            OP_SHIFT:   chain_q <= {ser_in, chain_q[CHAIN_W-1:1]};
            OP_CAPTURE: chain_q[FIELD_W-1:0] <= cap_word;
            default:    chain_q <= chain_q;
         endcase
      end
   end

   assign field_q = chain_q[FIELD_W-1:0];
   assign sel_q   = chain_q[CHAIN_W-1:FIELD_W];
   assign ser_out = chain_q[0];

   AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      op == OP_SHIFT |=> chain_q[CHAIN_W-2:0] == $past(chain_q[CHAIN_W-1:1])); // R2

   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
      op == OP_SHIFT |=> chain_q[CHAIN_W-1] == $past(ser_in)); // R2

   AST_SEL_RETAIN: assert property (@(posedge clk) disable iff (rst)
      op == OP_CAPTURE |=> sel_q == $past(sel_q)); // R9

   AST_UPDATE_KEEPS_CHAIN: assert property (@(posedge clk) disable iff (rst)
      op == OP_UPDATE |=> $stable(chain_q)); // R4

   AST_CHAIN_RESET: assert property (@(posedge clk)
      rst |=> chain_q == '0); // R1

endmodule

// File: rtl/upg_param_reg.sv
module upg_param_reg #(
   parameter int unsigned FIELD_W = 39
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [FIELD_W-1:0] d,
   output logic [FIELD_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   AST_PARAM_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q)); // R10

   AST_PARAM_LOAD: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(d)); // R4

   AST_PARAM_RESET: assert property (@(posedge clk)
      rst |=> q == '0); // R1

endmodule

// File: rtl/upg_ctl_chain.sv
module upg_ctl_chain
   import upg_chain_pkg::*;
#(
   parameter int unsigned FIELD_W = 39,
   parameter int unsigned PREV_W  = 31
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ser_in,
   input  logic               mode_shift,
   input  logic               mode_capture,
   input  logic [FIELD_W-1:0] live_state,
   input  logic [PREV_W-1:0]  prev_state_a,
   input  logic [PREV_W-1:0]  prev_state_b,
   output logic               ser_out,
   output logic [FIELD_W-1:0] cfg_word
);

   chain_op_e            op;
   logic [FIELD_W-1:0]   field_q;
   logic [SRC_SEL_W-1:0] sel_q;
   logic [FIELD_W-1:0]   cap_word;

   assign op = decode_op(mode_shift, mode_capture);

   upg_capture_mux #(.FIELD_W(FIELD_W), .PREV_W(PREV_W)) u_mux (
      .sel      (sel_q),
      .live     (live_state),
      .prev_a   (prev_state_a),
      .prev_b   (prev_state_b),
      .readback (cfg_word),
      .cap_word (cap_word)
   );

   upg_shift_chain #(.FIELD_W(FIELD_W)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .op       (op),
      .ser_in   (ser_in),
      .cap_word (cap_word),
      .field_q  (field_q),
      .sel_q    (sel_q),
      .ser_out  (ser_out)
   );

   upg_param_reg #(.FIELD_W(FIELD_W)) u_param (
      .clk  (clk),
      .rst  (rst),
      .load (op == OP_UPDATE),
      .d    (field_q),
      .q    (cfg_word)
   );

   AST_CAPTURE_READBACK: assert property (@(posedge clk) disable iff (rst)
      (op == OP_CAPTURE && sel_q == SRC_READBACK) |=> field_q == $past(cfg_word)); // R8

   AST_CAPTURE_LIVE: assert property (@(posedge clk) disable iff (rst)
      (op == OP_CAPTURE && sel_q == SRC_LIVE) |=> field_q == $past(live_state)); // R5

   AST_SHIFT_IGNORES_CAPT: assert property (@(posedge clk) disable iff (rst)
      mode_shift |=> $stable(cfg_word)); // R3

endmodule

// File: tb/upg_ctl_chain_bench.sv
module upg_ctl_chain_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ser_in = 1'b0;
   logic        mode_shift = 1'b1;
   logic        mode_capture = 1'b0;
   logic [38:0] live_state = '0;
   logic [30:0] prev_state_a = '0;
   logic [30:0] prev_state_b = '0;
   logic        ser_out;
   logic [38:0] cfg_word;

   int   n_vec = 0;
   int   n_bad = 0;
   logic done = 1'b0;
   logic [38:0] exp_cfg = '0;

   always #5 clk = ~clk;

   upg_ctl_chain u_upg_ctl_chain (
      .clk(clk), .rst(rst), .ser_in(ser_in),
      .mode_shift(mode_shift), .mode_capture(mode_capture),
      .live_state(live_state), .prev_state_a(prev_state_a),
      .prev_state_b(prev_state_b), .ser_out(ser_out), .cfg_word(cfg_word)
   );

   function automatic logic [40:0] pat(input int k);
      logic [63:0] x;
      x = 64'h9E3779B97F4A7C15 * 64'(k + 1);
      return x[40:0] ^ x[63:23];
   endfunction

   task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Shift a word in LSB first, toggling the capture control (R3).
   task automatic shift_word(input logic [40:0] v);
      for (int i = 0; i < 41; i++) begin
         mode_shift   = 1'b1;
         mode_capture = i[0];
         ser_in       = v[i];
         tick();
      end
      check("R10 cfg held over shift", {2'b0, cfg_word}, {2'b0, exp_cfg});
   endtask

   // Read the chain through ser_out; zeros refill it.
   task automatic read_word(output logic [40:0] r);
      for (int i = 0; i < 41; i++) begin
         r[i]         = ser_out;
         mode_shift   = 1'b1;
         mode_capture = 1'b1;
         ser_in       = 1'b0;
         tick();
      end
   endtask

   task automatic do_update(input logic [40:0] v);
      mode_shift   = 1'b0;
      mode_capture = 1'b0;
      tick();
      exp_cfg = v[38:0];
      check("R4 update loads cfg", {2'b0, cfg_word}, {2'b0, exp_cfg});
   endtask

   initial begin
      logic [40:0] r;
      logic [40:0] v;
      logic [38:0] src;
      @(negedge clk);
      repeat (3) tick();
      rst = 1'b0;
      check("R1 cfg reset", {2'b0, cfg_word}, 41'd0);
      check("R1 ser_out reset", {40'd0, ser_out}, 41'd0);
      read_word(r);
      check("R1 chain reset", r, 41'd0);

      // Shift / update sweep.
      for (int k = 0; k < 8; k++) begin
         v = pat(k);
         shift_word(v);
         do_update(v);
         read_word(r);
         check("R2 R3 R4 chain order and kept after update", r, v);
      end

      // Capture sweep over all selector codes.
      for (int s = 0; s < 4; s++) begin
         for (int k = 0; k < 6; k++) begin
            v = pat(100 + 10 * s + k);
            shift_word(v);
            do_update(v);
            live_state   = pat(200 + k)[38:0];
            prev_state_a = pat(300 + k)[40:10];
            prev_state_b = pat(400 + k)[30:0];
            shift_word({s[1:0], pat(500 + k)[38:0]});
            mode_shift   = 1'b0;
            mode_capture = 1'b1;
            tick();
            check("R10 cfg held over capture", {2'b0, cfg_word}, {2'b0, exp_cfg});
            tick();
            check("R10 cfg held over second capture", {2'b0, cfg_word}, {2'b0, exp_cfg});
            read_word(r);
            case (s)
               0: begin src = live_state;            check("R5 live source", {2'b0, r[38:0]}, {2'b0, src}); end
               1: begin src = {8'b0, prev_state_a}; check("R6 prev A padded", {2'b0, r[38:0]}, {2'b0, src}); end
               2: begin src = {8'b0, prev_state_b}; check("R7 prev B padded", {2'b0, r[38:0]}, {2'b0, src}); end
               default: begin src = exp_cfg;        check("R8 readback", {2'b0, r[38:0]}, {2'b0, src}); end
            endcase
            check("R9 selector kept", {39'd0, r[40:39]}, {39'd0, s[1:0]});
         end
      end

      // Synchronous reset mid-run clears the register (R1).
      rst = 1'b1;
      tick();
      rst = 1'b0;
      exp_cfg = '0;
      check("R1 cfg cleared by late reset", {2'b0, cfg_word}, 41'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule